// File: doc/BRIEF.md
# Process-Tagged Address Translator

This block turns a processor address into a physical address. Every request address carries a process number in its top bits. All processes therefore share one large virtual space, while each process still keeps a private translation table. A request whose process field is zero means "the process now running". For such a request the block fills in the number held in its current-process register, and only then selects a table.

The selected table maps the page-number bits to a physical frame. The in-page offset goes through unchanged. Each table entry holds a valid bit and a frame number. A lookup that hits an invalid entry returns a fault flag.

Translations are tagged by process, so a context switch only needs a new value in the current-process register. No table is flushed. Software loads the register and the tables through a separate write port. Requests and responses each use a valid/ready handshake, and a response appears one cycle after its request is accepted.

Top module: `pid_xlate`

## Requirements
- R1: A request address is 24 bits wide and splits into three fields. Bits [23:20] hold the process number, bits [19:12] the page and bits [11:0] the offset. The response address is {frame[11:0], offset}.
- R2: When the process field is 0, the value of the current-process register replaces it for table selection.
- R3: A non-zero process field selects that process's own table. The same page in different processes translates independently.
- R4: The offset bits of the response equal those of the request.
- R5: A lookup of an entry whose valid bit is 0 gives rsp_fault = 1. A lookup of a valid entry gives rsp_fault = 0.
- R6: A request accepted at one clock edge shows rsp_valid = 1 after that edge. If no request is accepted and the response is consumed or absent, rsp_valid is 0 after the next edge.
- R7: While rsp_valid = 1 and rsp_ready = 0, req_ready is 0 and the response address and fault stay unchanged.
- R8: A write to the current-process register takes effect for requests accepted on the following cycle. A request accepted in the same cycle as the write uses the old value.
- R9: A write of 0 to the current-process register is ignored, and the previous value is kept. Table writes naming process 0 are ignored.
- R10: After reset, rsp_valid = 0, req_ready = 1, the current process is 1 and every table entry is invalid.
- R11: Changing the current process leaves all table entries intact. Returning to a process finds its translations unchanged, with no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 24 | Tagged virtual address {process, page, offset} |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 24 | Physical address {frame, offset} |
| rsp_fault | output | 1 | Entry was invalid; rsp_paddr is don't-care |
| cur_we | input | 1 | Write the current-process register |
| cur_pid | input | 4 | New current process (0 ignored) |
| tbl_we | input | 1 | Write one table entry |
| tbl_pid | input | 4 | Process whose table is written (0 ignored) |
| tbl_page | input | 8 | Page index of the entry |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_frame | input | 12 | Frame number to store |

## Verification
The assertions check the handshake on every cycle:
- a held response stays stable and blocks new requests;
- each accepted request yields a response on the next cycle;
- the response's offset equals the request's offset;
- the current-process register never holds zero.

Only the bench scenarios can show the translation itself. They check that a zero process field picks up the current process, that separate processes resolve the same page to different frames, and that invalid entries fault. They also show timing and persistence: a register write made in the same cycle as a request does not affect that request, and translations survive a context switch.

// File: rtl/pid_xlate.sv
module pid_xlate #(
  parameter int PID_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [PID_W+PAGE_W+OFF_W-1:0] req_vaddr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [FRAME_W+OFF_W-1:0]    rsp_paddr,
  output logic                        rsp_fault,
  input  logic                        cur_we,
  input  logic [PID_W-1:0]            cur_pid,
  input  logic                        tbl_we,
  input  logic [PID_W-1:0]            tbl_pid,
  input  logic [PAGE_W-1:0]           tbl_page,
  input  logic                        tbl_valid,
  input  logic [FRAME_W-1:0]          tbl_frame
);
  localparam int VA_W  = PID_W + PAGE_W + OFF_W;
  localparam int IDX_W = PID_W + PAGE_W;
  localparam int NENT  = (2**PID_W - 1) * (2**PAGE_W);

  logic [PID_W-1:0]   cur_q;
  logic [FRAME_W-1:0] frame_mem [NENT];
  logic [NENT-1:0]    valid_q;

  wire [PID_W-1:0]  va_pid  = req_vaddr[VA_W-1 -: PID_W];
  wire [PAGE_W-1:0] va_page = req_vaddr[OFF_W +: PAGE_W];
  wire [OFF_W-1:0]  va_off  = req_vaddr[OFF_W-1:0];
  wire [PID_W-1:0]  eff_pid = (va_pid == '0) ? cur_q : va_pid;
  wire [IDX_W-1:0]  rd_idx  = {eff_pid - PID_W'(1), va_page};
  wire [IDX_W-1:0]  wr_idx  = {tbl_pid - PID_W'(1), tbl_page};
  wire              accept  = req_valid && req_ready;

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_q <= PID_W'(1);
    else if (cur_we && cur_pid != '0)
      cur_q <= cur_pid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else if (tbl_we && tbl_pid != '0)
      valid_q[wr_idx] <= tbl_valid;
  end

  always_ff @(posedge clk) begin
    if (tbl_we && tbl_pid != '0)
      frame_mem[wr_idx] <= tbl_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= {frame_mem[rd_idx], va_off};
      rsp_fault <= !valid_q[rd_idx];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_CUR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != '0); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R7
  AST_NO_ACCEPT_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R6
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && (!rsp_valid || rsp_ready) |=> !rsp_valid); // R6
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_paddr[OFF_W-1:0] == $past(va_off)); // R4
endmodule

// File: tb/pid_xlate_tb.sv
module pid_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic [23:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault;
  logic [23:0] rsp_paddr;
  logic cur_we = 0, tbl_we = 0, tbl_valid = 0;
  logic [3:0] cur_pid = '0, tbl_pid = '0;
  logic [7:0] tbl_page = '0;
  logic [11:0] tbl_frame = '0;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .cur_we(cur_we), .cur_pid(cur_pid),
    .tbl_we(tbl_we), .tbl_pid(tbl_pid), .tbl_page(tbl_page), .tbl_valid(tbl_valid),
    .tbl_frame(tbl_frame));

  // {vaddr, expected paddr, expected fault}; paddr ignored on fault
  localparam logic [48:0] VEC [8] = '{
    {24'h005ABC, 24'h3C3ABC, 1'b0},  // R2
    {24'h305123, 24'h3C3123, 1'b0},  // R3
    {24'h105FFF, 24'h0A1FFF, 1'b0},  // R3 R4
    {24'h205000, 24'h222000, 1'b0},  // R3
    {24'h0FF001, 24'hFFF001, 1'b0},  // R2 R1
    {24'hF00ABC, 24'h123ABC, 1'b0},  // R1
    {24'h007456, 24'h000000, 1'b1},  // R5
    {24'h406000, 24'h000000, 1'b1}   // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic [3:0] p, input logic [7:0] pg, input logic v, input logic [11:0] f);
    @(negedge clk);
    tbl_we = 1; tbl_pid = p; tbl_page = pg; tbl_valid = v; tbl_frame = f;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wr_cur(input logic [3:0] p);
    @(negedge clk);
    cur_we = 1; cur_pid = p;
    @(negedge clk);
    cur_we = 0;
  endtask

  task automatic do_req(input logic [23:0] va);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    rst_n = 1;
    @(negedge clk);
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 req_ready", req_ready, 1);
    do_req(24'h005ABC);
    chk("R10 empty table faults", rsp_fault, 1);

    wr_tbl(4'd1, 8'h05, 1, 12'h0A1);
    wr_tbl(4'd3, 8'h05, 1, 12'h3C3);
    wr_tbl(4'd3, 8'hFF, 1, 12'hFFF);
    wr_tbl(4'd15, 8'h00, 1, 12'h123);
    wr_tbl(4'd3, 8'h07, 0, 12'h777);
    wr_tbl(4'd2, 8'h05, 1, 12'h222);
    wr_tbl(4'd0, 8'h05, 1, 12'hBAD);
    do_req(24'h005ABC);
    chk("R2 reset current process is 1", rsp_paddr, 24'h0A1ABC);
    wr_cur(4'd3);

    for (int i = 0; i < 8; i++) begin
      do_req(VEC[i][48:25]);
      chk("R1-vector rsp_valid R6", rsp_valid, 1);
      chk("R5 fault", rsp_fault, VEC[i][0]);
      if (!VEC[i][0]) chk("R3 paddr", rsp_paddr, VEC[i][24:1]);
    end

    // R8: write and request in the same cycle
    @(negedge clk);
    cur_we = 1; cur_pid = 4'd2; req_valid = 1; req_vaddr = 24'h005111;
    @(negedge clk);
    cur_we = 0; req_valid = 0;
    chk("R8 same-cycle uses old", rsp_paddr, 24'h3C3111);
    do_req(24'h005222);
    chk("R8 next cycle uses new", rsp_paddr, 24'h222222);

    // R9: writing zero is ignored
    wr_cur(4'd0);
    do_req(24'h005333);
    chk("R9 zero write ignored", rsp_paddr, 24'h222333);

    // R11: return to process 3, entries kept
    wr_cur(4'd3);
    do_req(24'h005444);
    chk("R11 no flush", rsp_paddr, 24'h3C3444);

    // R7: backpressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = 24'h105010;
    @(negedge clk);
    req_vaddr = 24'h205020;
    chk("R7 valid held", rsp_valid, 1);
    chk("R7 req_ready low", req_ready, 0);
    @(negedge clk);
    chk("R7 paddr stable", rsp_paddr, 24'h0A1010);
    chk("R7 req_ready still low", req_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R7 second accepted after release", rsp_paddr, 24'h222020);
    @(negedge clk);
    chk("R6 drains to idle", rsp_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule